// File: doc/BRIEF.md
# Full-Duplex Serial Peripheral Controller (Host or Client)

This block moves characters over a four-wire synchronous serial link. Its role is chosen at run time. In host mode it paces every transfer: it generates the serial clock from a programmable divider, can drive the select line itself, shifts characters out on MOSI, and captures MISO on the same clock edges. In client mode it follows an external serial clock and select line. It resamples both into the system clock domain, receives on MOSI and answers on MISO.

A one-entry transmit holding register sits in front of the shift register. Software can therefore queue the next character while the current one is still shifting out, and consecutive characters go out back to back. Received characters enter a two-entry FIFO, which is read with a show-ahead port. Characters are 8 or 9 bits long, and the receiver can be switched off. Four flags report status: transmit buffer empty, receive data available, transmit complete and a sticky overflow.

Top module: `spi_duplex_ctrl`

## Requirements
- R1: After reset, flag_txe=1, flag_rxc=0, flag_txc=0, flag_ovf=0, sck_o=0 and ss_o=1.
- R2: With mode_host=1, sck_oe=1, mosi_oe=1 and miso_oe=0. With mode_host=0, sck_oe=0, mosi_oe=0, miso_oe=1 and ss_oe=0.
- R3: In host mode, sck_o idles low and has a period of 2*(baud+1) clock cycles. MOSI shows the most significant bit first and changes on falling edges. MISO is sampled on rising edges, and sck_o stays low whenever ss_o is high.
- R4: char9=1 selects 9-bit characters and char9=0 selects 8-bit characters, in both directions. With 8-bit characters, tx_data bit 8 is not sent and rx_data bit 8 reads 0.
- R5: tx_wr is accepted only while flag_txe=1. A write while flag_txe=0 is ignored. A held character enters the shift register at the falling edge that ends the current character, so sck_o runs without a gap.
- R6: In host mode, ss_oe equals sel_hw_en. ss_o goes low when the first character loads, stays low across back-to-back characters, and goes high after the last one.
- R7: Completed characters enter a two-entry FIFO in arrival order. rx_data shows the oldest entry, rx_rd removes it, and flag_rxc=1 while the FIFO holds data.
- R8: A character that completes while the FIFO holds two entries and rx_rd=0 is discarded and sets flag_ovf. flag_ovf stays set until ovf_clr. If rx_rd=1 in the completing cycle, the character is stored and no overflow is flagged.
- R9: flag_txc sets when a character completes with no character held. An accepted tx_wr clears it.
- R10: With rx_en=0, nothing is written to the FIFO and flag_ovf does not change.
- R11: In client mode, MOSI is sampled on rising edges of the resynchronised sck_i while ss_i is low. MISO presents the held character MSB first, or zeros if nothing is held, and each completed character is stored.
- R12: In client mode, raising ss_i in the middle of a character drops that partial character. The next selection starts on a fresh character boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_host | input | 1 | 1 = host role, 0 = client role |
| sel_hw_en | input | 1 | Host drives the select line when 1 |
| char9 | input | 1 | 1 = 9-bit characters, 0 = 8-bit |
| rx_en | input | 1 | Receiver enable |
| baud | input | 8 | Host clock divider; SCK period is 2*(baud+1) cycles |
| tx_data | input | 9 | Character to send |
| tx_wr | input | 1 | Write tx_data into the holding register |
| rx_data | output | 9 | Oldest received character |
| rx_rd | input | 1 | Remove the oldest received character |
| ovf_clr | input | 1 | Clear the overflow flag |
| flag_txe | output | 1 | Holding register empty |
| flag_rxc | output | 1 | Receive FIFO not empty |
| flag_txc | output | 1 | Transmission complete |
| flag_ovf | output | 1 | Sticky receive overflow |
| sck_i | input | 1 | Serial clock in (client) |
| sck_o | output | 1 | Serial clock out (host) |
| sck_oe | output | 1 | Serial clock output enable |
| mosi_i | input | 1 | Host-to-client data in (client) |
| mosi_o | output | 1 | Host-to-client data out (host) |
| mosi_oe | output | 1 | MOSI output enable |
| miso_i | input | 1 | Client-to-host data in (host) |
| miso_o | output | 1 | Client-to-host data out (client) |
| miso_oe | output | 1 | MISO output enable |
| ss_i | input | 1 | Select in, active low (client) |
| ss_o | output | 1 | Select out, active low (host) |
| ss_oe | output | 1 | Select output enable |

## Verification
The critical collision is a character completing into a full receive FIFO in the same clock cycle that software pops the oldest entry. The bench fills the FIFO with two looped-back characters and starts a third. It counts the host's rising SCK edges, then times rx_rd so that it is high exactly at the falling edge that ends the last bit. The bench passes only if flag_ovf stays clear and the FIFO then returns the second and third characters, in that order. A separate run without the pop confirms that the same arrival is discarded and flagged.

// File: rtl/spi_duplex_pkg.sv
package spi_duplex_pkg;
  localparam int unsigned CHAR_MAX = 9;
  localparam int unsigned CHAR_MIN = 8;

  typedef logic [CHAR_MAX-1:0] char_t;

  // keep only the bits that belong to the active character length
  function automatic char_t len_mask(input logic wide);
    return wide ? char_t'((1 << CHAR_MAX) - 1) : char_t'((1 << CHAR_MIN) - 1);
  endfunction
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= {STAGES{RST_VAL}};
    else     pipe <= {pipe[STAGES-2:0], d};
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/spi_sck_gen.sv
module spi_sck_gen #(
  parameter int BAUD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [BAUD_W-1:0] baud,
  output logic              sck,
  output logic              rise_evt,
  output logic              fall_evt
);
  logic [BAUD_W-1:0] cnt;
  logic              half_end;

  assign half_end = run && (cnt == baud);
  assign rise_evt = half_end && !sck;
  assign fall_evt = half_end && sck;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      sck <= 1'b0;
    end else if (half_end) begin
      cnt <= '0;
      sck <= ~sck;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/spi_rx_fifo.sv
module spi_rx_fifo #(
  parameter  int W     = 9,
  parameter  int DEPTH = 2,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [W-1:0]     wdata,
  input  logic             pop,
  output logic [W-1:0]     rdata,
  output logic             empty,
  output logic             full,
  output logic [LVL_W-1:0] level
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             do_push, do_pop;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (level == '0);
  assign full    = (level == LVL_W'(DEPTH));
  assign do_pop  = pop && !empty;
  assign do_push = push && (!full || do_pop);
  assign rdata   = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (do_push) wr_ptr <= step(wr_ptr);
      if (do_pop)  rd_ptr <= step(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/spi_duplex_ctrl.sv
module spi_duplex_ctrl
  import spi_duplex_pkg::*;
#(
  parameter int BAUD_W      = 8,
  parameter int RX_DEPTH    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_host,
  input  logic              sel_hw_en,
  input  logic              char9,
  input  logic              rx_en,
  input  logic [BAUD_W-1:0] baud,
  input  logic [8:0]        tx_data,
  input  logic              tx_wr,
  output logic [8:0]        rx_data,
  input  logic              rx_rd,
  input  logic              ovf_clr,
  output logic              flag_txe,
  output logic              flag_rxc,
  output logic              flag_txc,
  output logic              flag_ovf,
  input  logic              sck_i,
  output logic              sck_o,
  output logic              sck_oe,
  input  logic              mosi_i,
  output logic              mosi_o,
  output logic              mosi_oe,
  input  logic              miso_i,
  output logic              miso_o,
  output logic              miso_oe,
  input  logic              ss_i,
  output logic              ss_o,
  output logic              ss_oe
);
  localparam int CNT_W = $clog2(CHAR_MAX);
  localparam int LVL_W = $clog2(RX_DEPTH + 1);

  // holding register
  char_t txb;
  logic  txb_vld, wr_ok, take;

  // shift engine
  char_t            sh, load_val, rx_word, mask;
  logic             in_bit, busy, top_bit, in_pin;
  logic [CNT_W-1:0] bit_cnt, len_m1;
  logic             host_run, host_start, cl_start, cl_abort, load, char_done;
  logic             ev_rise, ev_fall;

  // host clock
  logic gen_sck, g_rise, g_fall;

  // client resync
  logic c_sck, c_ss, c_mosi, c_sck_d, c_rise, c_fall, c_sel;

  // receive path
  logic             push, fifo_empty, fifo_full, ovf_set;
  logic [LVL_W-1:0] rx_level;
  logic             txc_q, ovf_q;

  assign mask   = len_mask(char9);
  assign len_m1 = char9 ? CNT_W'(CHAR_MAX - 1) : CNT_W'(CHAR_MIN - 1);

  assign host_run = mode_host && busy;

  spi_sck_gen #(.BAUD_W(BAUD_W)) u_sck_gen (
    .clk      (clk),
    .rst      (rst),
    .run      (host_run),
    .baud     (baud),
    .sck      (gen_sck),
    .rise_evt (g_rise),
    .fall_evt (g_fall)
  );

  spi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({sck_i, ss_i, mosi_i}),
    .q   ({c_sck, c_ss, c_mosi})
  );

  always_ff @(posedge clk) begin
    if (rst) c_sck_d <= 1'b0;
    else     c_sck_d <= c_sck;
  end

  assign c_rise = c_sck && !c_sck_d;
  assign c_fall = !c_sck && c_sck_d;
  assign c_sel  = !c_ss;

  // one event source per role
  assign ev_rise = mode_host ? g_rise : (c_sel && busy && c_rise);
  assign ev_fall = mode_host ? g_fall : (c_sel && busy && c_fall);
  assign in_pin  = mode_host ? miso_i : c_mosi;

  assign char_done  = ev_fall && (bit_cnt == '0);
  assign host_start = mode_host && !busy && txb_vld;
  assign cl_start   = !mode_host && c_sel && !busy;
  assign cl_abort   = !mode_host && !c_sel;
  // host continues only with a held character, client always reloads
  assign load     = host_start || cl_start || (char_done && (txb_vld || !mode_host));
  assign take     = load && txb_vld;
  assign load_val = txb_vld ? txb : '0;
  assign rx_word  = {sh[CHAR_MAX-2:0], in_bit} & mask;
  assign top_bit  = char9 ? sh[CHAR_MAX-1] : sh[CHAR_MIN-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sh      <= '0;
      in_bit  <= 1'b0;
      bit_cnt <= '0;
      busy    <= 1'b0;
    end else if (cl_abort) begin
      busy    <= 1'b0;
      bit_cnt <= len_m1;
    end else begin
      if (ev_rise) in_bit <= rx_en ? in_pin : 1'b0;
      if (load) begin
        sh      <= load_val;
        bit_cnt <= len_m1;
        busy    <= 1'b1;
      end else if (char_done) begin
        busy    <= 1'b0;
      end else if (ev_fall) begin
        sh      <= {sh[CHAR_MAX-2:0], in_bit};
        bit_cnt <= bit_cnt - 1'b1;
      end
    end
  end

  // transmit holding register
  assign wr_ok = tx_wr && !txb_vld;

  always_ff @(posedge clk) begin
    if (rst) begin
      txb     <= '0;
      txb_vld <= 1'b0;
    end else if (wr_ok) begin
      txb     <= tx_data;
      txb_vld <= 1'b1;
    end else if (take) begin
      txb_vld <= 1'b0;
    end
  end

  // receive FIFO
  assign push    = char_done && rx_en;
  assign ovf_set = push && fifo_full && !rx_rd;

  spi_rx_fifo #(.W(CHAR_MAX), .DEPTH(RX_DEPTH)) u_rx_fifo (
    .clk   (clk),
    .rst   (rst),
    .push  (push),
    .wdata (rx_word),
    .pop   (rx_rd),
    .rdata (rx_data),
    .empty (fifo_empty),
    .full  (fifo_full),
    .level (rx_level)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      txc_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      if (wr_ok)                      txc_q <= 1'b0;
      else if (char_done && !txb_vld) txc_q <= 1'b1;
      if (ovf_set)                    ovf_q <= 1'b1;
      else if (ovf_clr)               ovf_q <= 1'b0;
    end
  end

  assign flag_txe = !txb_vld;
  assign flag_rxc = !fifo_empty;
  assign flag_txc = txc_q;
  assign flag_ovf = ovf_q;

  // pad directions by role
  assign sck_o   = gen_sck;
  assign sck_oe  = mode_host;
  assign mosi_o  = top_bit;
  assign mosi_oe = mode_host;
  assign miso_o  = top_bit;
  assign miso_oe = !mode_host;
  assign ss_o    = !host_run;
  assign ss_oe   = mode_host && sel_hw_en;
endmodule

// File: rtl/spi_duplex_chk.sv
module spi_duplex_chk #(
  parameter int RX_DEPTH = 2,
  parameter int LVL_W    = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             mode_host,
  input logic             rx_en,
  input logic             tx_wr,
  input logic             rx_rd,
  input logic             ovf_clr,
  input logic             flag_txe,
  input logic             flag_rxc,
  input logic             flag_ovf,
  input logic             sck_o,
  input logic             ss_o,
  input logic [LVL_W-1:0] rx_level
);
  // R5
  txe_take_chk: assert property (@(posedge clk) disable iff (rst)
    tx_wr && flag_txe |=> !flag_txe);

  // R8
  ovf_hold_chk: assert property (@(posedge clk) disable iff (rst)
    flag_ovf && !ovf_clr |=> flag_ovf);

  // R7
  fifo_bound_chk: assert property (@(posedge clk) disable iff (rst)
    rx_level <= LVL_W'(RX_DEPTH));

  // R10
  rx_off_chk: assert property (@(posedge clk) disable iff (rst)
    !rx_en && !flag_rxc |=> !flag_rxc);

  // R3
  sck_idle_chk: assert property (@(posedge clk) disable iff (rst)
    mode_host && ss_o |-> !sck_o);
endmodule

bind spi_duplex_ctrl spi_duplex_chk #(.RX_DEPTH(RX_DEPTH), .LVL_W(LVL_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .mode_host (mode_host),
  .rx_en     (rx_en),
  .tx_wr     (tx_wr),
  .rx_rd     (rx_rd),
  .ovf_clr   (ovf_clr),
  .flag_txe  (flag_txe),
  .flag_rxc  (flag_rxc),
  .flag_ovf  (flag_ovf),
  .sck_o     (sck_o),
  .ss_o      (ss_o),
  .rx_level  (rx_level)
);

// File: tb/test_spi_duplex_ctrl.sv
module test_spi_duplex_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;
  localparam int PP_BAUD    = 3;
  localparam int NVEC       = 6;
  // {char9, invert, baud[3:0], data[8:0], expected[8:0]}
  localparam logic [23:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 4'd1, 9'h0A5, 9'h0A5},
    {1'b1, 1'b0, 4'd0, 9'h1C3, 9'h1C3},
    {1'b0, 1'b1, 4'd2, 9'h03C, 9'h0C3},
    {1'b1, 1'b1, 4'd3, 9'h155, 9'h0AA},
    {1'b0, 1'b0, 4'd0, 9'h1FF, 9'h0FF},
    {1'b1, 1'b0, 4'd2, 9'h0FF, 9'h0FF}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic mode_host = 1'b1, sel_hw_en = 1'b0, char9 = 1'b0, rx_en = 1'b1;
  logic [7:0] baud = 8'd1;
  logic [8:0] tx_data = '0, rx_data;
  logic tx_wr = 1'b0, rx_rd = 1'b0, ovf_clr = 1'b0;
  logic flag_txe, flag_rxc, flag_txc, flag_ovf;
  logic sck_i = 1'b0, ss_i = 1'b1, mosi_i = 1'b0, lb_inv = 1'b0;
  logic sck_o, sck_oe, mosi_o, mosi_oe, miso_i, miso_o, miso_oe, ss_o, ss_oe;
  int n_chk = 0, n_bad = 0, cyc = 0;

  assign miso_i = mosi_o ^ lb_inv;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  spi_duplex_ctrl i_spi_duplex_ctrl (
    .clk(clk), .rst(rst), .mode_host(mode_host), .sel_hw_en(sel_hw_en),
    .char9(char9), .rx_en(rx_en), .baud(baud), .tx_data(tx_data),
    .tx_wr(tx_wr), .rx_data(rx_data), .rx_rd(rx_rd), .ovf_clr(ovf_clr),
    .flag_txe(flag_txe), .flag_rxc(flag_rxc), .flag_txc(flag_txc),
    .flag_ovf(flag_ovf), .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe),
    .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe), .miso_i(miso_i),
    .miso_o(miso_o), .miso_oe(miso_oe), .ss_i(ss_i), .ss_o(ss_o), .ss_oe(ss_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic host_wr(input logic [8:0] d);
    @(negedge clk); tx_data = d; tx_wr = 1'b1;
    @(negedge clk); tx_wr = 1'b0;
  endtask

  task automatic pop();
    @(negedge clk); rx_rd = 1'b1;
    @(negedge clk); rx_rd = 1'b0;
  endtask

  task automatic wait_txc();
    do @(negedge clk); while (flag_txc !== 1'b1);
  endtask

  // bench acting as host towards the client
  task automatic cl_bits(input logic [8:0] v, input int n, output logic [8:0] cap);
    cap = '0;
    for (int i = n - 1; i >= 0; i--) begin
      mosi_i = v[i];
      repeat (HALF) @(negedge clk);
      cap = {cap[7:0], miso_o};
      sck_i = 1'b1;
      repeat (HALF) @(negedge clk);
      sck_i = 1'b0;
    end
    repeat (HALF) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [8:0] cap;
    int t1, t2;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 txe", flag_txe, 1); chk("R1 rxc", flag_rxc, 0);
    chk("R1 txc", flag_txc, 0); chk("R1 ovf", flag_ovf, 0);
    chk("R1 sck", sck_o, 0);    chk("R1 ss", ss_o, 1);
    // R2 host directions, R6 select enable
    chk("R2 host oe", {sck_oe, mosi_oe, miso_oe}, 3'b110);
    chk("R6 ss_oe off", ss_oe, 0);
    sel_hw_en = 1'b1; @(negedge clk);
    chk("R6 ss_oe on", ss_oe, 1);

    // table walk: R3 R4 R9 over loopback
    for (int v = 0; v < NVEC; v++) begin
      char9 = VEC[v][23]; lb_inv = VEC[v][22]; baud = {4'd0, VEC[v][21:18]};
      host_wr(VEC[v][17:9]);
      chk("R9 txc cleared", flag_txc, 0);
      do @(negedge clk); while (sck_o !== 1'b1);
      t1 = cyc;
      chk("R3 msb first", mosi_o, char9 ? VEC[v][17] : VEC[v][16]);
      do @(negedge clk); while (sck_o !== 1'b0);
      do @(negedge clk); while (sck_o !== 1'b1);
      t2 = cyc;
      chk("R3 period", t2 - t1, 2 * (VEC[v][21:18] + 1));
      wait_txc();
      chk("R4 rx value", rx_data, VEC[v][8:0]);
      chk("R9 txc set", flag_txc, 1);
      pop();
      chk("R7 drained", flag_rxc, 0);
    end
    lb_inv = 1'b0;

    // R5 R6 back to back, ignored write while full
    char9 = 1'b0; baud = 8'd1;
    fork
      begin
        int rises = 0, first = 0, last = 0, ss_hi = 0;
        logic prev = 1'b0;
        while (rises < 16) begin
          @(negedge clk);
          if (sck_o && !prev) begin
            rises++;
            if (rises == 1) first = cyc;
            last = cyc;
          end
          if (rises > 0 && ss_o) ss_hi++;
          prev = sck_o;
        end
        chk("R5 no gap", last - first, 60);
        chk("R6 ss held low", ss_hi, 0);
      end
      begin
        host_wr(9'h096);
        do @(negedge clk); while (flag_txe !== 1'b1);
        host_wr(9'h03D);
        chk("R5 buffer full", flag_txe, 0);
        host_wr(9'h0EE);
      end
    join
    wait_txc();
    @(negedge clk);
    chk("R6 ss released", ss_o, 1);
    chk("R7 first in", rx_data, 9'h096);

    // R8 overflow discards
    host_wr(9'h011);
    wait_txc();
    chk("R8 ovf set", flag_ovf, 1);
    chk("R8 head kept", rx_data, 9'h096);
    pop();
    chk("R7 second", rx_data, 9'h03D);
    pop();
    chk("R5 ignored write not sent", flag_rxc, 0);
    chk("R8 sticky", flag_ovf, 1);
    @(negedge clk); ovf_clr = 1'b1; @(negedge clk); ovf_clr = 1'b0;
    chk("R8 cleared", flag_ovf, 0);

    // R8 push and pop in the same cycle
    baud = 8'(PP_BAUD);
    host_wr(9'h04B);
    do @(negedge clk); while (flag_txe !== 1'b1);
    host_wr(9'h0B4);
    wait_txc();
    host_wr(9'h07E);
    repeat (8) @(posedge sck_o);
    repeat (PP_BAUD) @(posedge clk);
    @(negedge clk); rx_rd = 1'b1;
    @(negedge clk); rx_rd = 1'b0;
    chk("R8 txc at collision", flag_txc, 1);
    chk("R8 no ovf on pop", flag_ovf, 0);
    chk("R8 order after pop", rx_data, 9'h0B4);
    pop();
    chk("R8 new kept", rx_data, 9'h07E);
    pop();
    chk("R7 empty", flag_rxc, 0);

    // R10 receiver disabled
    rx_en = 1'b0;
    host_wr(9'h05F);
    wait_txc();
    @(negedge clk);
    chk("R10 no store", flag_rxc, 0);
    chk("R10 no ovf", flag_ovf, 0);
    rx_en = 1'b1;

    // client role: R2 R11
    mode_host = 1'b0; char9 = 1'b0;
    @(negedge clk);
    chk("R2 client oe", {sck_oe, mosi_oe, miso_oe, ss_oe}, 4'b0010);
    host_wr(9'h03C);
    ss_i = 1'b0;
    repeat (HALF) @(negedge clk);
    cl_bits(9'h0A7, 8, cap);
    chk("R11 miso char", cap, 9'h03C);
    cl_bits(9'h05A, 8, cap);
    chk("R11 empty sends zero", cap, 9'h000);
    ss_i = 1'b1;
    repeat (HALF) @(negedge clk);
    chk("R11 rx first", rx_data, 9'h0A7);
    pop();
    chk("R11 rx second", rx_data, 9'h05A);
    pop();

    // R12 abort mid character
    ss_i = 1'b0;
    repeat (HALF) @(negedge clk);
    cl_bits(9'h005, 3, cap);
    ss_i = 1'b1;
    repeat (2 * HALF) @(negedge clk);
    chk("R12 partial dropped", flag_rxc, 0);
    host_wr(9'h081);
    ss_i = 1'b0;
    repeat (HALF) @(negedge clk);
    cl_bits(9'h0C6, 8, cap);
    ss_i = 1'b1;
    repeat (HALF) @(negedge clk);
    chk("R12 realigned tx", cap, 9'h081);
    chk("R12 realigned rx", rx_data, 9'h0C6);
    pop();
    chk("R12 single entry", flag_rxc, 0);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule